// File: doc/BRIEF.md
# Bus-Mapped JTAG Bit-Bang Port

This block sits on a processor's parallel bus as a single address and gives firmware bit-level control of a JTAG chain. A write to that address loads the chain's data-in, mode-select and test-clock levels into three registers clocked by the system clock. Firmware then produces every chain clock edge by issuing another write.

A read from the same address places the chain's returned data-out level and the three register values on the 4-bit data bus. This lets software check what it last wrote. The data bus is driven only during such a read and is released at all other times.

A cable-select input switches the chain's three drive lines from the registers to an external download cable. The cable always sees the chain's data-out. The registers keep their contents and can still be read and written while the cable has control.

Top module: `jtag_busport`

## Requirements
- R1: While `rst_n` is low, the three drive registers are 0. With the cable not selected, `chain_tck`, `chain_tms` and `chain_tdi` are then 0, and a read returns 0 in bits 2..0.
- R2: A write access is `bus_addr` equal to `PORT_ADDR`, `addr_strobe` high, `rd_wr` low and `data_strobe_n` low. On the first rising clock edge at which all four hold, the registers load TDI from data bit 0, TMS from bit 1 and TCK from bit 2. Data bit 3 has no effect.
- R3: No register changes on a clock edge where any one write condition is missing. This covers a different address, a low `addr_strobe`, a high `data_strobe_n`, or `rd_wr` high.
- R4: A read access is `bus_addr` equal to `PORT_ADDR`, `addr_strobe` high, `rd_wr` high and `data_strobe_n` low. During it, without waiting for a clock, `bus_data` carries bit 3 = `chain_tdo`, bit 2 = TCK register, bit 1 = TMS register and bit 0 = TDI register.
- R5: Whenever no read access is present, the block leaves `bus_data` undriven, so another bus master's value is seen unchanged.
- R6: With `cable_sel` high, `chain_tdi`, `chain_tms` and `chain_tck` follow `cable_tdi`, `cable_tms` and `cable_tck`. Writes still update the registers and reads still return them.
- R7: `cable_tdo` equals `chain_tdo` at all times, whatever the value of `cable_sel`.
- R8: With `cable_sel` low, the chain drive outputs equal the register values. A write therefore shows on the chain one clock edge after the write access is first presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the drive registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (20) | Processor address bus |
| addr_strobe | input | 1 | High while the address is valid |
| data_strobe_n | input | 1 | Low while the data phase is valid |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_data | inout | 4 | Bidirectional processor data bus |
| cable_sel | input | 1 | 1 hands the chain to the download cable |
| cable_tdi | input | 1 | Cable data-in level |
| cable_tms | input | 1 | Cable mode-select level |
| cable_tck | input | 1 | Cable test clock |
| cable_tdo | output | 1 | Chain data-out returned to the cable |
| chain_tdi | output | 1 | Data-in to the JTAG chain |
| chain_tms | output | 1 | Mode-select to the JTAG chain |
| chain_tck | output | 1 | Test clock to the JTAG chain |
| chain_tdo | input | 1 | Data-out from the JTAG chain |

## Verification
A register that is stored wrongly, loaded on a missed qualifier, or left unchanged when it should load shows on the chain outputs one clock edge after the access. The same fault shows in the next read of bits 2..0. A fault in the read decode or the bus driver shows in the same cycle as the access: a read returns the wrong nibble, or the bus value from another master is corrupted. A fault in the cable multiplexer shows at once on the chain drive lines when `cable_sel` or the cable inputs change.

// File: rtl/jtag_busport_pkg.sv
package jtag_busport_pkg;

  localparam int BUS_DATA_W = 4;
  localparam int POS_TDI    = 0;
  localparam int POS_TMS    = 1;
  localparam int POS_TCK    = 2;
  localparam int POS_TDO    = 3;

  typedef struct packed {
    logic tck;
    logic tms;
    logic tdi;
  } jtag_drive_t;

  function automatic jtag_drive_t unpack_write(input logic [BUS_DATA_W-1:0] d);
    jtag_drive_t r;
    r.tdi = d[POS_TDI];
    r.tms = d[POS_TMS];
    r.tck = d[POS_TCK];
    return r;
  endfunction

  function automatic logic [BUS_DATA_W-1:0] pack_readback(input logic tdo,
                                                          input jtag_drive_t r);
    logic [BUS_DATA_W-1:0] d;
    d          = '0;
    d[POS_TDI] = r.tdi;
    d[POS_TMS] = r.tms;
    d[POS_TCK] = r.tck;
    d[POS_TDO] = tdo;
    return d;
  endfunction

  function automatic logic addr_hit(input logic [31:0] addr, input logic [31:0] mine,
                                    input logic strobe);
    return strobe && (addr == mine);
  endfunction

endpackage

// File: rtl/jbp_access_decode.sv
module jbp_access_decode
  import jtag_busport_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              addr_strobe,
  input  logic              data_strobe_n,
  input  logic              rd_wr,
  output logic              wr_fire,
  output logic              rd_fire
);
  logic [31:0] addr_ext;
  logic [31:0] mine_ext;
  logic        selected;

  assign addr_ext = 32'(bus_addr);
  assign mine_ext = 32'(PORT_ADDR);
  assign selected = addr_hit(addr_ext, mine_ext, addr_strobe);

  assign wr_fire = selected && !rd_wr && !data_strobe_n;
  assign rd_fire = selected &&  rd_wr && !data_strobe_n;
endmodule

// File: rtl/jbp_drive_regs.sv
module jbp_drive_regs
  import jtag_busport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [BUS_DATA_W-1:0] wr_data,
  output jtag_drive_t           drive_q
);
  jtag_drive_t next_val;
  assign next_val = unpack_write(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drive_q <= '0;
    else if (wr_fire) drive_q <= next_val;
  end

  // R1: reset holds the registers clear
  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |-> drive_q == '0);

  // R2: a write access loads bits 2..0 on the next edge
  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> drive_q == $past(wr_data[2:0]));

  // R3: without a write access the registers hold
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(drive_q));
endmodule

// File: rtl/jbp_chain_mux.sv
module jbp_chain_mux
  import jtag_busport_pkg::*;
#(
  parameter int LINES = 3
) (
  input  logic             cable_sel,
  input  logic [LINES-1:0] from_regs,
  input  logic [LINES-1:0] from_cable,
  output logic [LINES-1:0] to_chain
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign to_chain[i] = cable_sel ? from_cable[i] : from_regs[i];
  end
endmodule

// File: rtl/jtag_busport.sv
module jtag_busport
  import jtag_busport_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 20'hA5C30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              addr_strobe,
  input  logic              data_strobe_n,
  input  logic              rd_wr,
  inout  wire  [3:0]        bus_data,
  input  logic              cable_sel,
  input  logic              cable_tdi,
  input  logic              cable_tms,
  input  logic              cable_tck,
  output logic              cable_tdo,
  output logic              chain_tdi,
  output logic              chain_tms,
  output logic              chain_tck,
  input  logic              chain_tdo
);
  localparam int LINES = 3;

  logic                  wr_fire;
  logic                  rd_fire;
  jtag_drive_t           drive_q;
  logic [BUS_DATA_W-1:0] readback;
  logic [LINES-1:0]      cable_vec;
  logic [LINES-1:0]      chain_vec;

  jbp_access_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
    .bus_addr      (bus_addr),
    .addr_strobe   (addr_strobe),
    .data_strobe_n (data_strobe_n),
    .rd_wr         (rd_wr),
    .wr_fire       (wr_fire),
    .rd_fire       (rd_fire)
  );

  jbp_drive_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_data (bus_data),
    .drive_q (drive_q)
  );

  assign cable_vec = {cable_tck, cable_tms, cable_tdi};

  jbp_chain_mux #(.LINES(LINES)) u_mux (
    .cable_sel  (cable_sel),
    .from_regs  (drive_q),
    .from_cable (cable_vec),
    .to_chain   (chain_vec)
  );

  assign {chain_tck, chain_tms, chain_tdi} = chain_vec;
  assign cable_tdo = chain_tdo;

  assign readback = pack_readback(chain_tdo, drive_q);
  assign bus_data = rd_fire ? readback : 4'bzzzz;

  // R4: a read right after a write returns the written bits
  assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && $past(wr_fire)) |-> bus_data[2:0] == $past(bus_data[2:0]));

  // R8: with the cable off, a write reaches the chain one edge later
  assert_chain_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cable_sel && $past(wr_fire)) |-> {chain_tck, chain_tms, chain_tdi} == $past(bus_data[2:0]));

  // R6: cable selected means cable levels on the chain
  assert_cable_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cable_sel |-> {chain_tck, chain_tms, chain_tdi} == {cable_tck, cable_tms, cable_tdi});

  // R7: returned data-out reaches the cable
  assert_tdo_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cable_tdo == chain_tdo);
endmodule

// File: tb/jtag_busport_bench.sv
module jtag_busport_bench;
  localparam logic [19:0] MY_ADDR = 20'hA5C30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        addr_strobe = 1'b0;
  logic        data_strobe_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic        cable_sel = 1'b0;
  logic        cable_tdi = 1'b0, cable_tms = 1'b0, cable_tck = 1'b0;
  logic        chain_tdo = 1'b0;
  logic        cable_tdo, chain_tdi, chain_tms, chain_tck;
  logic        tb_drv_en = 1'b0;
  logic [3:0]  tb_drv_val = '0;
  wire  [3:0]  bus_data;

  assign bus_data = tb_drv_en ? tb_drv_val : 4'bzzzz;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  // reference model state: index 0 tdi, 1 tms, 2 tck
  bit ref_q[3] = '{0, 0, 0};

  always #10 clk = ~clk;

  jtag_busport u_jtag_busport (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
    .data_strobe_n(data_strobe_n), .rd_wr(rd_wr), .bus_data(bus_data),
    .cable_sel(cable_sel), .cable_tdi(cable_tdi), .cable_tms(cable_tms),
    .cable_tck(cable_tck), .cable_tdo(cable_tdo), .chain_tdi(chain_tdi),
    .chain_tms(chain_tms), .chain_tck(chain_tck), .chain_tdo(chain_tdo)
  );

  task automatic check1(string tag, logic [3:0] got, logic [3:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    bit is_read;
    logic [3:0] exp_chain;
    is_read = (bus_addr == MY_ADDR) && addr_strobe && rd_wr && !data_strobe_n;
    exp_chain = cable_sel ? {1'b0, cable_tck, cable_tms, cable_tdi}
                          : {1'b0, 1'(ref_q[2]), 1'(ref_q[1]), 1'(ref_q[0])};
    check1({tag, " chain"}, {1'b0, chain_tck, chain_tms, chain_tdi}, exp_chain);
    check1("R7 cable_tdo", {3'b0, cable_tdo}, {3'b0, chain_tdo});
    if (is_read)
      check1({tag, " read"}, bus_data,
             {chain_tdo, 1'(ref_q[2]), 1'(ref_q[1]), 1'(ref_q[0])});
    else if (tb_drv_en)
      check1({tag, " bus free R5"}, bus_data, tb_drv_val);
  endtask

  // one bus cycle: apply, compare before the edge, update the model at the edge
  task automatic step(string tag, logic [19:0] a, bit as, bit ds_n, bit rw,
                      bit drv, logic [3:0] val);
    bit is_write;
    @(negedge clk);
    bus_addr = a; addr_strobe = as; data_strobe_n = ds_n; rd_wr = rw;
    tb_drv_en = drv; tb_drv_val = val;
    #6;
    compare(tag);
    is_write = (a == MY_ADDR) && as && !rw && !ds_n;
    @(posedge clk);
    if (!rst_n) ref_q = '{0, 0, 0};
    else if (is_write) begin
      ref_q[0] = val[0]; ref_q[1] = val[1]; ref_q[2] = val[2];
    end
  endtask

  task automatic wr(string tag, logic [3:0] v);
    step(tag, MY_ADDR, 1, 0, 0, 1, v);
  endtask
  task automatic rd(string tag);
    step(tag, MY_ADDR, 1, 0, 1, 0, 4'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rd("R1");
    wr("R1", 4'h7);
    rd("R1");
    @(negedge clk); rst_n = 1'b1;
    rd("R1");
    // R2: writes, bit 3 ignored
    wr("R2", 4'h7);
    rd("R4");
    wr("R2", 4'hA);
    rd("R4");
    chain_tdo = 1'b1;
    rd("R4");
    wr("R2", 4'h8);
    rd("R2");
    // R3: each missing qualifier
    wr("R2", 4'h5);
    step("R3", MY_ADDR ^ 20'h1, 1, 0, 0, 1, 4'h2);
    step("R3", MY_ADDR, 0, 0, 0, 1, 4'h2);
    step("R3", MY_ADDR, 1, 1, 0, 1, 4'h2);
    step("R3", MY_ADDR, 1, 1, 1, 1, 4'h2);
    rd("R3");
    // R5: other traffic seen unchanged
    step("R5", 20'h00010, 1, 0, 1, 1, 4'h9);
    step("R5", MY_ADDR, 0, 0, 1, 1, 4'h6);
    step("R5", MY_ADDR, 1, 1, 1, 1, 4'hC);
    // R6: cable takes over
    cable_sel = 1'b1;
    for (int k = 0; k < 8; k++) begin
      {cable_tck, cable_tms, cable_tdi} = 3'(k);
      chain_tdo = k[0];
      rd("R6");
    end
    wr("R6", 4'h3);
    rd("R6");
    chain_tdo = 1'b0;
    rd("R7");
    // R8: back to register control, all patterns
    cable_sel = 1'b0;
    for (int k = 0; k < 16; k++) begin
      wr("R8", 4'(k));
      chain_tdo = ~chain_tdo;
      rd("R8");
    end
    // R1: reset again mid-run
    wr("R8", 4'h7);
    @(negedge clk); rst_n = 1'b0;
    ref_q = '{0, 0, 0};
    rd("R1");
    @(negedge clk); rst_n = 1'b1;
    rd("R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule